// File: doc/BRIEF.md
# Timer Input Capture Unit

This block stamps transitions on an external capture pin with the value of a free-running 16-bit timer count that arrives as an input. The pin is brought into the clock domain by a two-stage synchronizer. It can then pass through an optional digital filter, which accepts a new level only after four identical successive samples. An edge detector compares successive samples of the resulting level, and a polarity control picks whether rising or falling transitions qualify.

On a qualifying transition the block copies the count into its capture register and sets a capture flag. While an interrupt enable is high, that flag drives an interrupt request. Software clears the flag with a write-one strobe. The timer can also use the capture register as its period limit. While it does, the pin is ignored, and the register accepts software writes instead.

Top module: `icp_unit`

## Requirements
- R1: After reset, `cap_val` is 0, `cap_flag` is 0 and `cap_irq` is 0.
- R2: With `filt_en`=0 and `edge_rise`=1, a pin change from 0 to 1 made between clock edges sets `cap_flag` on the third rising clock edge after the change. At that edge, `cap_val` takes the `cnt_val` present at that same edge.
- R3: With `edge_rise`=0, a 1-to-0 pin change triggers a capture. With `edge_rise`=1, a 1-to-0 change does not. Conversely, with `edge_rise`=0 a 0-to-1 change does not trigger a capture.
- R4: With `filt_en`=1, a pin pulse held for fewer than four clock cycles causes no capture. A pulse held for four or more cycles causes one.
- R5: With `filt_en`=1, a capture lands exactly four clock edges later than it does with `filt_en`=0, which is the seventh rising edge after the pin change.
- R6: `cap_irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R7: A one-cycle `flag_clr` pulse clears `cap_flag`. If a capture happens at the same edge, the flag stays 1.
- R8: While `icr_is_top`=1, pin transitions neither set `cap_flag` nor change `cap_val`, and an `icr_wr` pulse loads `icr_wdata` into `cap_val`. While `icr_is_top`=0, `icr_wr` leaves `cap_val` unchanged.
- R9: Toggling `edge_rise` while the pin is held steady causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_pin | input | 1 | Raw, asynchronous capture pin |
| cnt_val | input | 16 | Current timer count |
| filt_en | input | 1 | Enables the four-sample filter |
| edge_rise | input | 1 | 1: a rising edge qualifies; 0: a falling edge qualifies |
| irq_en | input | 1 | Capture interrupt enable |
| icr_is_top | input | 1 | Capture register serves as the timer period limit |
| icr_wr | input | 1 | Software write strobe for the capture register |
| icr_wdata | input | 16 | Software write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cap_val | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The capture path is driven with single pulses of widths from one to six cycles, in both polarities, with and without the filter. This separates the filter's acceptance threshold (three cycles rejected, four accepted) from leading-edge versus trailing-edge qualification. A counter that advances every cycle during an isolated pin change pins down the exact capture edge: the captured count reveals the latency on each path. Directed sequences combine a clear with a simultaneous capture, toggle polarity over a steady pin, and apply pulses and writes in period-limit mode, so that each priority rule is observed at the outputs.

// File: rtl/icp_unit.sv
module icp_unit #(
  parameter int CW     = 16,
  parameter int FDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pin,
  input  logic [CW-1:0] cnt_val,
  input  logic          filt_en,
  input  logic          edge_rise,
  input  logic          irq_en,
  input  logic          icr_is_top,
  input  logic          icr_wr,
  input  logic [CW-1:0] icr_wdata,
  input  logic          flag_clr,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          cap_irq
);
  localparam int HW = FDEPTH - 1;

  logic [1:0]    sync_q;
  logic [HW-1:0] hist_q;
  logic          filt_q, prev_q, flag_q;
  logic [CW-1:0] cap_q;

  wire s2      = sync_q[1];
  wire all_hi  = &{hist_q, s2};
  wire all_lo  = ~|{hist_q, s2};
  wire lvl     = filt_en ? filt_q : s2;
  wire rise_e  = lvl & ~prev_q;
  wire fall_e  = ~lvl & prev_q;
  wire cap_evt = !icr_is_top && (edge_rise ? rise_e : fall_e);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], cap_pin};
      hist_q <= {hist_q[HW-2:0], s2};
      if (all_hi)      filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      if (cap_evt)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (cap_evt)                  cap_q <= cnt_val;
      else if (icr_is_top && icr_wr) cap_q <= icr_wdata;
    end
  end

  assign cap_val  = cap_q;
  assign cap_flag = flag_q;
  assign cap_irq  = flag_q & irq_en;

  AST_TOP_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> !$past(icr_is_top)); // R8
  AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !(icr_is_top && icr_wr)) |=> $stable(cap_val)); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !cap_flag); // R7
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag); // R7
  AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(all_hi) || $past(all_lo))); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !cap_irq); // R6
endmodule

// File: tb/icp_unit_tb.sv
module icp_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_pin = 1'b0, filt_en = 1'b0, edge_rise = 1'b1, irq_en = 1'b0;
  logic icr_is_top = 1'b0, icr_wr = 1'b0, flag_clr = 1'b0;
  logic [15:0] cnt_val = '0, icr_wdata = '0;
  logic [15:0] cap_val;
  logic cap_flag, cap_irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  icp_unit dut_i (.clk, .rst_n, .cap_pin, .cnt_val, .filt_en, .edge_rise, .irq_en,
    .icr_is_top, .icr_wr, .icr_wdata, .flag_clr, .cap_val, .cap_flag, .cap_irq);

  // {filt_en, edge_rise, expect_capture, 1'b0, width[3:0]}
  localparam logic [7:0] VEC [9] = '{
    8'b0110_0001, 8'b0110_0011, 8'b0010_0001, 8'b0010_0101,
    8'b1100_0011, 8'b1110_0100, 8'b1000_0010, 8'b1010_0110, 8'b1100_0001 };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(cap_val == 0 && cap_flag == 0 && cap_irq == 0, "R1 reset", cap_val, 0);

    foreach (VEC[i]) begin
      logic idle;
      filt_en = VEC[i][7]; edge_rise = VEC[i][6];
      idle = ~VEC[i][6];
      cap_pin = idle; cyc(10);
      clr_flag();
      cnt_val = 16'h1000 + 16'(i);
      cap_pin = ~idle; cyc(int'(VEC[i][3:0]));
      cap_pin = idle; cyc(12);
      chk(cap_flag == VEC[i][5], "R3/R4 vector flag", cap_flag, VEC[i][5]);
      if (VEC[i][5])
        chk(cap_val == cnt_val, "R3/R4 vector value", cap_val, cnt_val);
    end

    // R2 / R5 exact latency using a moving count
    for (int f = 0; f < 2; f++) begin
      int lat;
      filt_en = f[0]; edge_rise = 1'b1; cap_pin = 1'b0; cyc(10); clr_flag();
      lat = f ? 7 : 3;
      cnt_val = 16'd100; cap_pin = 1'b1;
      for (int k = 1; k <= lat; k++) begin
        @(posedge clk); @(negedge clk);
        if (k == lat - 1) chk(cap_flag == 0, f ? "R5 early" : "R2 early", cap_flag, 0);
        cnt_val = 16'(100 + k);
      end
      chk(cap_flag == 1, f ? "R5 flag" : "R2 flag", cap_flag, 1);
      chk(cap_val == 16'(100 + lat - 1), f ? "R5 value" : "R2 value", cap_val, 100 + lat - 1);
    end

    // R6 interrupt gating (flag is 1 here)
    irq_en = 1'b0; cyc(1);
    chk(cap_irq == 0, "R6 disabled", cap_irq, 0);
    irq_en = 1'b1; cyc(1);
    chk(cap_irq == 1, "R6 enabled", cap_irq, 1);

    // R7 capture wins over a simultaneous clear
    filt_en = 1'b0; edge_rise = 1'b1; cap_pin = 1'b0; cyc(10);
    chk(cap_flag == 1, "R7 precondition", cap_flag, 1);
    cnt_val = 16'h0BEE; cap_pin = 1'b1;
    cyc(2); flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk(cap_flag == 1 && cap_val == 16'h0BEE, "R7 capture wins", cap_val, 16'h0BEE);
    clr_flag();
    chk(cap_flag == 0 && cap_irq == 0, "R7 clear", cap_flag, 0);
    chk(cap_irq == 0, "R6 flag low", cap_irq, 0);

    // R9 polarity toggle over a steady pin
    cyc(5);
    edge_rise = 1'b0; cyc(3); edge_rise = 1'b1; cyc(3); edge_rise = 1'b0; cyc(5);
    chk(cap_flag == 0, "R9 no spurious capture", cap_flag, 0);

    // R8 period-limit mode
    edge_rise = 1'b1; cap_pin = 1'b0; cyc(5); icr_is_top = 1'b1;
    cnt_val = 16'h5555; cap_pin = 1'b1; cyc(8);
    chk(cap_flag == 0 && cap_val == 16'h0BEE, "R8 pin ignored", cap_val, 16'h0BEE);
    icr_wdata = 16'hA5A5; icr_wr = 1'b1; cyc(1); icr_wr = 1'b0;
    chk(cap_val == 16'hA5A5, "R8 write in top mode", cap_val, 16'hA5A5);
    icr_is_top = 1'b0; cyc(2);
    icr_wdata = 16'h1234; icr_wr = 1'b1; cyc(1); icr_wr = 1'b0;
    chk(cap_val == 16'hA5A5 && cap_flag == 0, "R8 write ignored", cap_val, 16'hA5A5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule